// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside one processor core and owns the bookkeeping for up to 256 interrupt vectors. It keeps three 256-bit vectors (pending requests, vectors in service, and the trigger kind of each request) and from them decides whether the core should be interrupted. Requests arrive one per cycle on an accept port; the core takes an interrupt with an acknowledge strobe and gets back a vector number, and later retires the current handler with an end-of-interrupt strobe.

Priority works by class: a vector's upper four bits form its class. A processor priority is formed from the task priority that software programs and from the highest vector in service. A pending request only raises the interrupt line when its class is strictly above the class of that processor priority (or when the processor priority is zero). A spurious-vector register carries a global enable bit and the vector handed back when an acknowledge cannot be honoured.

Top module: `vipc_top`

## Requirements
- R1: An accept (`acc_valid_i`) sets bit `acc_vec_i` of `irr_o` one cycle later; the same bit of `tmr_o` becomes 1 when `acc_level_i` is 1 and 0 when it is 0.
- R2: The pending vector chosen for signalling and acknowledge is the highest-numbered set bit of `irr_o`.
- R3: `irq_o` is 1 only when bit 8 of `svr_o` is 1 and at least one bit of `irr_o` is set.
- R4: The processor priority equals the task priority (`tpr_rdata_o` shifted into bits 7:4) when the task class is at least the class of the highest in-service vector, else that in-service vector with bits 3:0 cleared; `irq_o` is 0 when the processor priority is nonzero and the pending vector's bits 7:4 are less than or equal to its bits 7:4.
- R5: One cycle after `ack_i`, `ack_valid_o` is 1 for one cycle; if bit 8 of `svr_o` is 0, nothing is pending, or the task priority is nonzero and the pending vector is less than or equal to it (full 8-bit compare), `ack_vec_o` is `svr_o[7:0]` and no state changes; otherwise `ack_vec_o` is the pending vector, whose `irr_o` bit is cleared and `isr_o` bit set.
- R6: `eoi_i` clears the highest set bit of `isr_o`; with `isr_o` all zero it changes nothing.
- R7: `tpr_we_i` stores `tpr_wdata_i[3:0]` as task priority bits 7:4 (bits 3:0 zero); `tpr_rdata_o` returns those four bits; upper write bits are dropped.
- R8: After reset `svr_o` is 0x0FF, `irr_o`, `isr_o`, `tmr_o` and `tpr_rdata_o` are zero, and `irq_o` and `ack_valid_o` are 0.
- R9: `svr_we_i` keeps only bits 8:0 of `svr_wdata_i`.
- R10: Accepting a vector that is already pending leaves exactly one request bit set for it.
- R11: In one cycle the end-of-interrupt clear applies first, then the acknowledge move, then the accept set; an accept of the vector being acknowledged leaves it pending, and an acknowledge of the vector being retired leaves it in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Accept a request this cycle |
| acc_vec_i | input | 8 | Vector being accepted |
| acc_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | 8 | Vector returned for the acknowledge |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Task priority write enable |
| tpr_wdata_i | input | 8 | Task priority write data (bits 3:0 used) |
| tpr_rdata_o | output | 4 | Task priority class |
| svr_we_i | input | 1 | Spurious-vector register write enable |
| svr_wdata_i | input | 32 | Spurious-vector register write data |
| svr_o | output | 9 | Spurious-vector register (bit 8 enable) |
| irr_o | output | 256 | Pending request bits |
| isr_o | output | 256 | In-service bits |
| tmr_o | output | 256 | Trigger kind bits |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Two pairs of strobes can coincide: an accept landing in the cycle the same vector is acknowledged, and an end-of-interrupt landing in the cycle an acknowledge re-enters the same vector. The bench provokes each by driving both strobes on one clock edge, then judges the outcome at the ports: the acknowledged vector is returned and its request bit stays set in the first case, and its in-service bit survives the retirement in the second. A table of single-strobe operations walks the class comparison, the spurious return and the enable bit before these directed collisions.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
    localparam int unsigned VEC_W_DEF = 8;
    localparam int unsigned CLS_W_DEF = 4;
    localparam int unsigned BUS_W_DEF = 32;
endpackage

// File: rtl/vipc_msb_find.sv
module vipc_msb_find #(
    parameter int unsigned N  = 256,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vipc_prio_eval.sv
module vipc_prio_eval #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned CLS_W = 4
) (
    input  logic             sw_en_i,
    input  logic             req_found_i,
    input  logic [VEC_W-1:0] req_idx_i,
    input  logic             svc_found_i,
    input  logic [VEC_W-1:0] svc_idx_i,
    input  logic [VEC_W-1:0] task_pri_i,
    output logic [VEC_W-1:0] proc_pri_o,
    output logic             irq_ok_o,
    output logic             ack_take_o
);
    localparam int unsigned SUB_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] task_cls, svc_cls, req_cls, proc_cls;

    assign task_cls = task_pri_i[VEC_W-1:SUB_W];
    assign svc_cls  = svc_idx_i[VEC_W-1:SUB_W];
    assign req_cls  = req_idx_i[VEC_W-1:SUB_W];

    always_comb begin
        if (!svc_found_i || task_cls >= svc_cls) begin
            proc_pri_o = task_pri_i;
        end else begin
            proc_pri_o = {svc_cls, {SUB_W{1'b0}}};
        end
    end

    assign proc_cls = proc_pri_o[VEC_W-1:SUB_W];

    assign irq_ok_o = sw_en_i && req_found_i &&
                      !((proc_pri_o != '0) && (req_cls <= proc_cls));

    assign ack_take_o = sw_en_i && req_found_i &&
                        !((task_pri_i != '0) && (req_idx_i <= task_pri_i));
endmodule

// File: rtl/vipc_top.sv
module vipc_top #(
    parameter int unsigned VEC_W = vipc_pkg::VEC_W_DEF,
    parameter int unsigned CLS_W = vipc_pkg::CLS_W_DEF,
    parameter int unsigned BUS_W = vipc_pkg::BUS_W_DEF
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     acc_valid_i,
    input  logic [VEC_W-1:0]         acc_vec_i,
    input  logic                     acc_level_i,
    input  logic                     ack_i,
    output logic                     ack_valid_o,
    output logic [VEC_W-1:0]         ack_vec_o,
    input  logic                     eoi_i,
    input  logic                     tpr_we_i,
    input  logic [VEC_W-1:0]         tpr_wdata_i,
    output logic [CLS_W-1:0]         tpr_rdata_o,
    input  logic                     svr_we_i,
    input  logic [BUS_W-1:0]         svr_wdata_i,
    output logic [VEC_W:0]           svr_o,
    output logic [(1<<VEC_W)-1:0]    irr_o,
    output logic [(1<<VEC_W)-1:0]    isr_o,
    output logic [(1<<VEC_W)-1:0]    tmr_o,
    output logic                     irq_o
);
    localparam int unsigned NUM_VEC = 1 << VEC_W;
    localparam int unsigned SUB_W   = VEC_W - CLS_W;
    localparam int unsigned SVR_W   = VEC_W + 1;
    localparam logic [SVR_W-1:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [CLS_W-1:0]   tpr_cls;
        logic [SVR_W-1:0]   svr;
        logic               ack_v;
        logic [VEC_W-1:0]   ack_vec;
    } state_t;

    state_t st_q, st_d;

    logic             req_found, svc_found, irq_ok, ack_take;
    logic [VEC_W-1:0] req_idx, svc_idx, task_pri, proc_pri;

    assign task_pri = {st_q.tpr_cls, {SUB_W{1'b0}}};

    vipc_msb_find #(.N(NUM_VEC), .IW(VEC_W)) req_find_i (
        .bits_i  (st_q.irr),
        .found_o (req_found),
        .idx_o   (req_idx)
    );

    vipc_msb_find #(.N(NUM_VEC), .IW(VEC_W)) svc_find_i (
        .bits_i  (st_q.isr),
        .found_o (svc_found),
        .idx_o   (svc_idx)
    );

    vipc_prio_eval #(.VEC_W(VEC_W), .CLS_W(CLS_W)) eval_i (
        .sw_en_i     (st_q.svr[VEC_W]),
        .req_found_i (req_found),
        .req_idx_i   (req_idx),
        .svc_found_i (svc_found),
        .svc_idx_i   (svc_idx),
        .task_pri_i  (task_pri),
        .proc_pri_o  (proc_pri),
        .irq_ok_o    (irq_ok),
        .ack_take_o  (ack_take)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack_v = 1'b0;
        // retirement first
        if (eoi_i && svc_found) begin
            st_d.isr[svc_idx] = 1'b0;
        end
        // acknowledge move second
        if (ack_i) begin
            st_d.ack_v = 1'b1;
            if (ack_take) begin
                st_d.irr[req_idx] = 1'b0;
                st_d.isr[req_idx] = 1'b1;
                st_d.ack_vec      = req_idx;
            end else begin
                st_d.ack_vec      = st_q.svr[VEC_W-1:0];
            end
        end
        // new request last
        if (acc_valid_i) begin
            st_d.irr[acc_vec_i] = 1'b1;
            st_d.tmr[acc_vec_i] = acc_level_i;
        end
        if (tpr_we_i) begin
            st_d.tpr_cls = tpr_wdata_i[CLS_W-1:0];
        end
        if (svr_we_i) begin
            st_d.svr = svr_wdata_i[SVR_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.irr     <= '0;
            st_q.isr     <= '0;
            st_q.tmr     <= '0;
            st_q.tpr_cls <= '0;
            st_q.svr     <= SVR_RST;
            st_q.ack_v   <= 1'b0;
            st_q.ack_vec <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_valid_o = st_q.ack_v;
    assign ack_vec_o   = st_q.ack_vec;
    assign tpr_rdata_o = st_q.tpr_cls;
    assign svr_o       = st_q.svr;
    assign irr_o       = st_q.irr;
    assign isr_o       = st_q.isr;
    assign tmr_o       = st_q.tmr;
    assign irq_o       = irq_ok;
endmodule

// File: rtl/vipc_chk.sv
module vipc_chk #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned CLS_W = 4
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  acc_valid_i,
    input logic [VEC_W-1:0]      acc_vec_i,
    input logic                  acc_level_i,
    input logic                  ack_i,
    input logic                  ack_valid_o,
    input logic                  eoi_i,
    input logic                  tpr_we_i,
    input logic [VEC_W-1:0]      tpr_wdata_i,
    input logic [CLS_W-1:0]      tpr_rdata_o,
    input logic [VEC_W:0]        svr_o,
    input logic [(1<<VEC_W)-1:0] irr_o,
    input logic [(1<<VEC_W)-1:0] isr_o,
    input logic [(1<<VEC_W)-1:0] tmr_o,
    input logic                  irq_o
);
    logic live_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    AST_ACCEPT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && acc_valid_i |=> irr_o[$past(acc_vec_i)]); // R1
    AST_ACCEPT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && acc_valid_i |=> tmr_o[$past(acc_vec_i)] == $past(acc_level_i)); // R1
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> svr_o[VEC_W]); // R3
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irr_o != '0)); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && ack_valid_o |-> $past(ack_i)); // R5
    AST_EOI_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && eoi_i && !ack_i |=>
        $countones(isr_o) == $countones($past(isr_o)) - (($past(isr_o) != '0) ? 1 : 0)); // R6
    AST_TPR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && tpr_we_i |=> tpr_rdata_o == $past(tpr_wdata_i[CLS_W-1:0])); // R7
endmodule

bind vipc_top vipc_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_vec_i   (acc_vec_i),
    .acc_level_i (acc_level_i),
    .ack_i       (ack_i),
    .ack_valid_o (ack_valid_o),
    .eoi_i       (eoi_i),
    .tpr_we_i    (tpr_we_i),
    .tpr_wdata_i (tpr_wdata_i),
    .tpr_rdata_o (tpr_rdata_o),
    .svr_o       (svr_o),
    .irr_o       (irr_o),
    .isr_o       (isr_o),
    .tmr_o       (tmr_o),
    .irq_o       (irq_o)
);

// File: tb/vipc_top_tb_top.sv
module vipc_top_tb_top;
    logic         clk_i = 1'b0;
    logic         rst_ni;
    logic         acc_valid_i, acc_level_i, ack_i, eoi_i, tpr_we_i, svr_we_i;
    logic [7:0]   acc_vec_i, tpr_wdata_i;
    logic [31:0]  svr_wdata_i;
    logic         ack_valid_o, irq_o;
    logic [7:0]   ack_vec_o;
    logic [3:0]   tpr_rdata_o;
    logic [8:0]   svr_o;
    logic [255:0] irr_o, isr_o, tmr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    vipc_top dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .acc_valid_i(acc_valid_i), .acc_vec_i(acc_vec_i), .acc_level_i(acc_level_i),
        .ack_i(ack_i), .ack_valid_o(ack_valid_o), .ack_vec_o(ack_vec_o),
        .eoi_i(eoi_i), .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
        .tpr_rdata_o(tpr_rdata_o), .svr_we_i(svr_we_i), .svr_wdata_i(svr_wdata_i),
        .svr_o(svr_o), .irr_o(irr_o), .isr_o(isr_o), .tmr_o(tmr_o), .irq_o(irq_o)
    );

    // op codes: 1 accept (arg[8] = level), 2 ack, 3 eoi, 4 task priority, 5 spurious reg
    // entry: {op[2:0], arg[8:0], exp_irq, exp_ack[7:0], req[3:0]}
    localparam int NT = 18;
    localparam logic [24:0] TBL [NT] = '{
        {3'd5, 9'h1EF, 1'b0, 8'h00, 4'd3},   // R3 enable, nothing pending
        {3'd1, 9'h045, 1'b1, 8'h00, 4'd3},   // R3 pending + enabled
        {3'd1, 9'h132, 1'b1, 8'h00, 4'd1},   // R1 level accept
        {3'd2, 9'h000, 1'b0, 8'h45, 4'd2},   // R2 highest taken; R4 class 3 <= 4
        {3'd1, 9'h051, 1'b1, 8'h00, 4'd4},   // R4 class 5 above in-service 4
        {3'd2, 9'h000, 1'b0, 8'h51, 4'd5},   // R5 moved to service
        {3'd3, 9'h000, 1'b0, 8'h00, 4'd6},   // R6 retires 0x51, 0x45 still masks
        {3'd3, 9'h000, 1'b1, 8'h00, 4'd6},   // R6 retires 0x45
        {3'd4, 9'h003, 1'b0, 8'h00, 4'd4},   // R4 task class 3 masks 0x32
        {3'd2, 9'h000, 1'b0, 8'h32, 4'd5},   // R5 0x32 above 0x30 still taken
        {3'd3, 9'h000, 1'b0, 8'h00, 4'd6},
        {3'd1, 9'h030, 1'b0, 8'h00, 4'd4},   // R4 equal class masked
        {3'd2, 9'h000, 1'b0, 8'hEF, 4'd5},   // R5 spurious at 0x30 <= 0x30
        {3'd4, 9'h002, 1'b1, 8'h00, 4'd4},
        {3'd5, 9'h0EF, 1'b0, 8'h00, 4'd3},   // R3 disabled
        {3'd5, 9'h1EF, 1'b1, 8'h00, 4'd3},
        {3'd2, 9'h000, 1'b0, 8'h30, 4'd5},
        {3'd3, 9'h000, 1'b0, 8'h00, 4'd6}
    };

    task automatic idle_inputs();
        acc_valid_i = 0; acc_level_i = 0; acc_vec_i = 0; ack_i = 0; eoi_i = 0;
        tpr_we_i = 0; tpr_wdata_i = 0; svr_we_i = 0; svr_wdata_i = 0;
    endtask

    task automatic tick();
        @(posedge clk_i);
        @(negedge clk_i);
        idle_inputs();
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        idle_inputs();
        rst_ni = 0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1;

        // R8 reset state
        check("R8 svr", 32'(svr_o), 32'h0FF);
        check("R8 irr", 32'(irr_o != 0), 0);
        check("R8 isr", 32'(isr_o != 0), 0);
        check("R8 tmr", 32'(tmr_o != 0), 0);
        check("R8 tpr", 32'(tpr_rdata_o), 0);
        check("R8 irq/ack", {30'd0, irq_o, ack_valid_o}, 0);

        // table walk
        for (int k = 0; k < NT; k++) begin
            logic [2:0] op;
            logic [8:0] arg;
            op  = TBL[k][24:22];
            arg = TBL[k][21:13];
            case (op)
                3'd1: begin acc_valid_i = 1; acc_vec_i = arg[7:0]; acc_level_i = arg[8]; end
                3'd2: ack_i = 1;
                3'd3: eoi_i = 1;
                3'd4: begin tpr_we_i = 1; tpr_wdata_i = arg[7:0]; end
                3'd5: begin svr_we_i = 1; svr_wdata_i = 32'(arg); end
                default: ;
            endcase
            tick();
            check($sformatf("R%0d irq step %0d", TBL[k][3:0], k), 32'(irq_o), 32'(TBL[k][12]));
            if (op == 3'd2) begin
                check($sformatf("R%0d ack step %0d", TBL[k][3:0], k),
                      {23'd0, ack_valid_o, ack_vec_o}, {23'd1, TBL[k][11:4]});
            end
        end
        // table leaves: svr 0x1EF, task class 2, nothing pending or in service
        tpr_we_i = 1; tpr_wdata_i = 8'h5A; tick();
        check("R7 tpr read keeps low nibble", 32'(tpr_rdata_o), 32'hA);
        tpr_we_i = 1; tpr_wdata_i = 8'h00; tick();

        // R1 trigger kind set then cleared
        acc_valid_i = 1; acc_vec_i = 8'h77; acc_level_i = 1; tick();
        check("R1 tmr level", 32'(tmr_o[8'h77]), 1);
        acc_valid_i = 1; acc_vec_i = 8'h77; acc_level_i = 0; tick();
        check("R1 tmr edge", 32'(tmr_o[8'h77]), 0);
        check("R10 single request bit", $countones(irr_o), 1);

        // R2 highest-numbered wins
        acc_valid_i = 1; acc_vec_i = 8'h01; tick();
        acc_valid_i = 1; acc_vec_i = 8'hFE; tick();
        ack_i = 1; tick();
        check("R2 highest vector", 32'(ack_vec_o), 32'hFE);
        eoi_i = 1; tick();
        ack_i = 1; tick();
        check("R2 next highest", 32'(ack_vec_o), 32'h77);
        eoi_i = 1; tick();
        ack_i = 1; tick();
        check("R2 lowest", 32'(ack_vec_o), 32'h01);
        eoi_i = 1; tick();
        check("R6 all retired", 32'(isr_o != 0), 0);

        // R6 eoi with nothing in service
        acc_valid_i = 1; acc_vec_i = 8'h90; tick();
        eoi_i = 1; tick();
        check("R6 empty eoi isr", 32'(isr_o != 0), 0);
        check("R6 empty eoi irr", 32'(irr_o[8'h90]), 1);

        // R11 accept and ack of the same vector in one cycle
        ack_i = 1; acc_valid_i = 1; acc_vec_i = 8'h90; tick();
        check("R11 ack vector", 32'(ack_vec_o), 32'h90);
        check("R11 still pending", 32'(irr_o[8'h90]), 1);
        check("R11 in service", 32'(isr_o[8'h90]), 1);
        // R11 eoi and ack of the same vector in one cycle
        ack_i = 1; eoi_i = 1; tick();
        check("R11 eoi+ack isr kept", 32'(isr_o[8'h90]), 1);
        check("R11 eoi+ack irr moved", 32'(irr_o[8'h90]), 0);
        eoi_i = 1; tick();

        // R5 ack while disabled returns spurious; R9 write mask
        svr_we_i = 1; svr_wdata_i = 32'hFFFF_FE55; tick();
        check("R9 svr mask", 32'(svr_o), 32'h055);
        acc_valid_i = 1; acc_vec_i = 8'hC0; tick();
        ack_i = 1; tick();
        check("R5 disabled ack", {23'd0, ack_valid_o, ack_vec_o}, {23'd1, 8'h55});
        check("R5 disabled no move", 32'(irr_o[8'hC0]), 1);
        tick();
        check("R5 ack valid one cycle", 32'(ack_valid_o), 0);
        check("R3 disabled irq", 32'(irq_o), 0);

        report();
    end
endmodule